// File: doc/BRIEF.md
# Tower-Field Normal-Basis GF(2^8) Inverter

This block returns the multiplicative inverse of a byte that is already expressed in tower-field coordinates, GF(2^8) built as GF(((2^2)^2)^2), with a normal basis at every level. It is purely combinational: a new byte on the input gives its inverse on the output within the same cycle, with no clock, register or handshake. It is meant to sit between a basis-change matrix and an affine step inside a cipher substitution stage; those surrounding steps are left to the instantiating logic.

Each level has trace one, so the unit element is all ones at every level and inversion in GF(2^2) is a bit swap. The byte is split into a GF(2^4) pair, a correction term made from the half product and a scaled square of the half sum is inverted one level down, and the two output halves are that inverse times the opposite input half. The two norm constants (the GF(2^2) norm and the GF(2^4) norm) are parameters; half sums that feed two multipliers are formed once and passed to both.

Top module: `gf256_nb_inv`

## Requirements
- R1: For every nonzero input, the product of input and output in the tower field is 8'hFF, the unit element. Bit layout: [7:4] is the coefficient of the upper conjugate and [3:0] of the lower one; inside each nibble [3:2] is the upper GF(2^2) coefficient and [1:0] the lower; inside each pair bit 1 is the upper and bit 0 the lower basis element.
- R2: An input of 8'h00 gives an output of 8'h00.
- R3: Applying the block to its own output returns the original input for every byte value.
- R4: The GF(2^4) inverter gives an output whose product with the input is 4'hF for each nonzero nibble and 4'h0 for zero; its last GF(2^2) inversion is a swap of the two bits of the pair.
- R5: The GF(2^4) multiplier, given the operands and their half sums, equals the tower-field product for all 256 operand pairs.
- R6: The GF(2^2) multiplier equals the field product for all 16 operand pairs, where 2'b11 is one, 2'b01 the lower basis element z and 2'b10 its square.
- R7: The GF(2^4) square-scaler returns n times the square of its input for all 16 inputs, with n the GF(2^4) norm parameter.
- R8: The GF(2^2) norm parameter may be 2'b01 or 2'b10 and the GF(2^4) norm any nibble of odd bit parity; with the other GF(2^2) norm 2'b01 and GF(2^4) norm 4'b0100, R1 still holds for every nonzero input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Element to invert, tower-field normal-basis coordinates |
| a_out | output | 8 | Inverse of a_in in the same coordinates, zero for zero |

## Verification
Zero, the unit 8'hFF and single-half bytes such as 8'hF0 and 8'h0F are applied first, since they exercise the paths where one GF(2^4) half is zero and the inner correction term reduces to a pure scaled square. A random sweep and then an exhaustive sweep compare each output against an inverse found by search with a multiplier written from the schoolbook product, which separates a wrong wiring of the output halves from a wrong norm constant. Feeding every output back tells a true inverse from a mapping that is merely one-to-one, and the second parameter set shows that the scaler networks follow their parameters rather than one fixed constant.

// File: rtl/tfinv_pkg.sv
package tfinv_pkg;

  localparam int PAIR_W = 2;
  localparam int NIB_W  = 2 * PAIR_W;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [PAIR_W-1:0] gf4_t;
  typedef logic [NIB_W-1:0]  gf16_t;
  typedef logic [BYTE_W-1:0] gf256_t;

  // GF(2^2) product, normal basis (z^2, z)
  function automatic gf4_t gf4_mul(gf4_t e, gf4_t f);
    logic s;
    s = (e[1] ^ e[0]) & (f[1] ^ f[0]);
    return {(e[1] & f[1]) ^ s, (e[0] & f[0]) ^ s};
  endfunction

  // squaring in a normal basis is a rotation of the coordinates
  function automatic gf4_t gf4_sq(gf4_t e);
    return {e[0], e[1]};
  endfunction

  function automatic gf16_t gf16_mul(gf16_t c, gf16_t d, gf4_t nrm);
    gf4_t hh, ll, ee;
    hh = gf4_mul(c[3:2], d[3:2]);
    ll = gf4_mul(c[1:0], d[1:0]);
    ee = gf4_mul(gf4_mul(c[3:2] ^ c[1:0], d[3:2] ^ d[1:0]), nrm);
    return {hh ^ ee, ll ^ ee};
  endfunction

  function automatic gf16_t gf16_sq(gf16_t c, gf4_t nrm);
    gf4_t t;
    t = gf4_mul(gf4_sq(c[3:2] ^ c[1:0]), nrm);
    return {gf4_sq(c[3:2]) ^ t, gf4_sq(c[1:0]) ^ t};
  endfunction

  function automatic gf16_t gf16_sqscale(gf16_t c, gf16_t nu, gf4_t nrm);
    return gf16_mul(gf16_sq(c, nrm), nu, nrm);
  endfunction

  function automatic gf256_t gf256_mul(gf256_t a, gf256_t b, gf16_t nu, gf4_t nrm);
    gf16_t hh, ll, ee;
    hh = gf16_mul(a[7:4], b[7:4], nrm);
    ll = gf16_mul(a[3:0], b[3:0], nrm);
    ee = gf16_mul(gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0], nrm), nu, nrm);
    return {hh ^ ee, ll ^ ee};
  endfunction

endpackage

// File: rtl/gf4_mul_nb.sv
module gf4_mul_nb
  import tfinv_pkg::*;
(
  input  gf4_t e,
  input  gf4_t f,
  input  logic e_fold,
  input  logic f_fold,
  output gf4_t p
);

  logic shared_and;

  // the half sums arrive precomputed so that callers can share them
  assign shared_and = e_fold & f_fold;
  assign p = {(e[1] & f[1]) ^ shared_and, (e[0] & f[0]) ^ shared_and};

  always_comb begin
    if (!$isunknown({e, f, e_fold, f_fold})) begin
      assert_fold_match_R6: assert ((e_fold == (e[1] ^ e[0])) && (f_fold == (f[1] ^ f[0])))
        else $error("gf4 multiplier fed an inconsistent half sum");
      assert_zero_product_R6: assert ((p == '0) == ((e == '0) || (f == '0)))
        else $error("gf4 product zero mismatch");
    end
  end

endmodule

// File: rtl/gf4_scale_nb.sv
module gf4_scale_nb
  import tfinv_pkg::*;
#(
  parameter logic [1:0] NORM   = 2'b10,
  parameter bit         SQUARE = 1'b0
)(
  input  gf4_t e,
  output gf4_t y
);

  // NORM is z (2'b01) or z^2 (2'b10); SQUARE selects NORM*e^2 instead of NORM*e
  generate
    if (NORM == 2'b01 && !SQUARE) begin : g_z_lin
      assign y = {e[1] ^ e[0], e[1]};
    end else if (NORM == 2'b01) begin : g_z_sq
      assign y = {e[1] ^ e[0], e[0]};
    end else if (!SQUARE) begin : g_z2_lin
      assign y = {e[0], e[1] ^ e[0]};
    end else begin : g_z2_sq
      assign y = {e[1], e[1] ^ e[0]};
    end
  endgenerate

endmodule

// File: rtl/gf16_mul_nb.sv
module gf16_mul_nb
  import tfinv_pkg::*;
#(
  parameter logic [1:0] NORM = 2'b10
)(
  input  gf16_t x,
  input  gf16_t y,
  input  gf4_t  x_fold,
  input  gf4_t  y_fold,
  output gf16_t p
);

  gf4_t hh, ll, mid, ee;
  logic xh_f, xl_f, yh_f, yl_f, xs_f, ys_f;

  assign xh_f = x[3] ^ x[2];
  assign xl_f = x[1] ^ x[0];
  assign yh_f = y[3] ^ y[2];
  assign yl_f = y[1] ^ y[0];
  assign xs_f = x_fold[1] ^ x_fold[0];
  assign ys_f = y_fold[1] ^ y_fold[0];

  gf4_mul_nb u_hi  (.e(x[3:2]), .f(y[3:2]), .e_fold(xh_f), .f_fold(yh_f), .p(hh));
  gf4_mul_nb u_lo  (.e(x[1:0]), .f(y[1:0]), .e_fold(xl_f), .f_fold(yl_f), .p(ll));
  gf4_mul_nb u_mid (.e(x_fold), .f(y_fold), .e_fold(xs_f), .f_fold(ys_f), .p(mid));

  gf4_scale_nb #(.NORM(NORM), .SQUARE(1'b0)) u_scl (.e(mid), .y(ee));

  assign p = {hh ^ ee, ll ^ ee};

  always_comb begin
    if (!$isunknown({x, y, x_fold, y_fold})) begin
      assert_fold_match_R5: assert ((x_fold == (x[3:2] ^ x[1:0])) && (y_fold == (y[3:2] ^ y[1:0])))
        else $error("gf16 multiplier fed an inconsistent half sum");
      assert_zero_product_R5: assert ((p == '0) == ((x == '0) || (y == '0)))
        else $error("gf16 product zero mismatch");
    end
  end

endmodule

// File: rtl/gf16_inv_nb.sv
module gf16_inv_nb
  import tfinv_pkg::*;
#(
  parameter logic [1:0] NORM = 2'b10
)(
  input  gf16_t c,
  output gf16_t d
);

  gf4_t ch, cl, csum, prod, sqs, delta, theta, dh, dl;
  logic ch_f, cl_f, th_f;

  assign ch   = c[3:2];
  assign cl   = c[1:0];
  assign csum = ch ^ cl;
  assign ch_f = ch[1] ^ ch[0];
  assign cl_f = cl[1] ^ cl[0];

  gf4_mul_nb u_prod (.e(ch), .f(cl), .e_fold(ch_f), .f_fold(cl_f), .p(prod));
  gf4_scale_nb #(.NORM(NORM), .SQUARE(1'b1)) u_sqs (.e(csum), .y(sqs));

  assign delta = prod ^ sqs;
  // GF(2^2) inverse: swap the two coordinates
  assign theta = {delta[0], delta[1]};
  assign th_f  = theta[1] ^ theta[0];

  // half sums of theta, ch and cl each feed two multipliers
  gf4_mul_nb u_oh (.e(theta), .f(cl), .e_fold(th_f), .f_fold(cl_f), .p(dh));
  gf4_mul_nb u_ol (.e(theta), .f(ch), .e_fold(th_f), .f_fold(ch_f), .p(dl));

  assign d = {dh, dl};

  always_comb begin
    if (!$isunknown(c)) begin
      assert_inv_zero_R4: assert ((d == '0) == (c == '0))
        else $error("gf16 inverse zero mismatch");
      if (c != '0) begin
        assert_inv_unit_R4: assert (gf16_mul(c, d, NORM) == 4'hF)
          else $error("gf16 inverse product is not one");
      end
    end
  end

endmodule

// File: rtl/gf16_sqscale_nb.sv
module gf16_sqscale_nb
  import tfinv_pkg::*;
#(
  parameter logic [1:0] NORM = 2'b10,
  parameter logic [3:0] NU   = 4'b1101
)(
  input  gf16_t a,
  output gf16_t y
);

  // both factors are constants, so this folds to a fixed XOR network
  assign y = gf16_sqscale(a, NU, NORM);

  always_comb begin
    if (!$isunknown(a)) begin
      assert_sqscale_zero_R7: assert ((y == '0) == (a == '0))
        else $error("square-scaler zero mismatch");
    end
  end

endmodule

// File: rtl/gf256_nb_inv.sv
module gf256_nb_inv
  import tfinv_pkg::*;
#(
  parameter logic [1:0] NORM = 2'b10,
  parameter logic [3:0] NU   = 4'b1101
)(
  input  logic [7:0] a_in,
  output logic [7:0] a_out
);

  gf16_t ah, al, asum, prod, sqs, delta, theta, oh, ol;
  gf4_t  ah_f, al_f, th_f;

  assign ah   = a_in[7:4];
  assign al   = a_in[3:0];
  assign asum = ah ^ al;
  assign ah_f = ah[3:2] ^ ah[1:0];
  assign al_f = al[3:2] ^ al[1:0];

  gf16_mul_nb #(.NORM(NORM)) u_prod (
    .x(ah), .y(al), .x_fold(ah_f), .y_fold(al_f), .p(prod)
  );

  gf16_sqscale_nb #(.NORM(NORM), .NU(NU)) u_sqs (.a(asum), .y(sqs));

  assign delta = prod ^ sqs;

  gf16_inv_nb #(.NORM(NORM)) u_inv (.c(delta), .d(theta));

  assign th_f = theta[3:2] ^ theta[1:0];

  gf16_mul_nb #(.NORM(NORM)) u_oh (
    .x(theta), .y(al), .x_fold(th_f), .y_fold(al_f), .p(oh)
  );
  gf16_mul_nb #(.NORM(NORM)) u_ol (
    .x(theta), .y(ah), .x_fold(th_f), .y_fold(ah_f), .p(ol)
  );

  assign a_out = {oh, ol};

  always_comb begin
    if (!$isunknown(a_in)) begin
      assert_zero_map_R2: assert ((a_out == '0) == (a_in == '0))
        else $error("zero handling mismatch");
      if (a_in != '0) begin
        assert_product_one_R1: assert (gf256_mul(a_in, a_out, NU, NORM) == 8'hFF)
          else $error("input times output is not one");
      end
    end
  end

endmodule

// File: tb/gf256_nb_inv_test.sv
module gf256_nb_inv_test;

  localparam logic [1:0] N_A  = 2'b10;
  localparam logic [3:0] NU_A = 4'b1101;
  localparam logic [1:0] N_B  = 2'b01;
  localparam logic [3:0] NU_B = 4'b0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] a_in, a_out, b_in, b_out;
  logic [3:0] m16_x, m16_y, m16_p, i16_c, i16_d, s16_a, s16_y;
  logic [1:0] m16_xf, m16_yf, m4_e, m4_f, m4_p;
  logic       m4_ef, m4_ff;

  gf256_nb_inv #(.NORM(N_A), .NU(NU_A)) uut (.a_in(a_in), .a_out(a_out));
  gf256_nb_inv #(.NORM(N_B), .NU(NU_B)) alt_uut (.a_in(b_in), .a_out(b_out));
  gf16_mul_nb #(.NORM(N_A)) m16 (.x(m16_x), .y(m16_y), .x_fold(m16_xf), .y_fold(m16_yf), .p(m16_p));
  gf16_inv_nb #(.NORM(N_A)) i16 (.c(i16_c), .d(i16_d));
  gf16_sqscale_nb #(.NORM(N_A), .NU(NU_A)) s16 (.a(s16_a), .y(s16_y));
  gf4_mul_nb m4 (.e(m4_e), .f(m4_f), .e_fold(m4_ef), .f_fold(m4_ff), .p(m4_p));

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // GF(4) via exponents of z: 2'b11 = z^0, 2'b01 = z^1, 2'b10 = z^2
  function automatic int lg4(logic [1:0] v);
    return (v == 2'b11) ? 0 : (v == 2'b01) ? 1 : 2;
  endfunction

  function automatic logic [1:0] b4_mul(logic [1:0] a, logic [1:0] b);
    int k;
    if (a == 2'b00 || b == 2'b00) return 2'b00;
    k = (lg4(a) + lg4(b)) % 3;
    return (k == 0) ? 2'b11 : (k == 1) ? 2'b01 : 2'b10;
  endfunction

  // schoolbook product, upper basis squared reduces to (N+1, N) and so on
  function automatic logic [3:0] b16_mul(logic [3:0] c, logic [3:0] d, logic [1:0] nn);
    logic [1:0] hh, ll, cr, n1;
    n1 = nn ^ 2'b11;
    hh = b4_mul(c[3:2], d[3:2]);
    ll = b4_mul(c[1:0], d[1:0]);
    cr = b4_mul(c[3:2], d[1:0]) ^ b4_mul(c[1:0], d[3:2]);
    return {b4_mul(hh, n1) ^ b4_mul(cr, nn) ^ b4_mul(ll, nn),
            b4_mul(hh, nn) ^ b4_mul(cr, nn) ^ b4_mul(ll, n1)};
  endfunction

  function automatic logic [7:0] b256_mul(logic [7:0] a, logic [7:0] b, logic [3:0] nu, logic [1:0] nn);
    logic [3:0] hh, ll, cr, n1;
    n1 = nu ^ 4'hF;
    hh = b16_mul(a[7:4], b[7:4], nn);
    ll = b16_mul(a[3:0], b[3:0], nn);
    cr = b16_mul(a[7:4], b[3:0], nn) ^ b16_mul(a[3:0], b[7:4], nn);
    return {b16_mul(hh, n1, nn) ^ b16_mul(cr, nu, nn) ^ b16_mul(ll, nu, nn),
            b16_mul(hh, nu, nn) ^ b16_mul(cr, nu, nn) ^ b16_mul(ll, n1, nn)};
  endfunction

  function automatic logic [7:0] b256_inv(logic [7:0] a, logic [3:0] nu, logic [1:0] nn);
    for (int k = 1; k < 256; k++)
      if (b256_mul(a, 8'(k), nu, nn) == 8'hFF) return 8'(k);
    return 8'h00;
  endfunction

  function automatic logic [3:0] b16_inv(logic [3:0] c, logic [1:0] nn);
    for (int k = 1; k < 16; k++)
      if (b16_mul(c, 4'(k), nn) == 4'hF) return 4'(k);
    return 4'h0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply_byte(input logic [7:0] v);
    @(negedge clk);
    a_in = v;
    b_in = v;
    #1;
  endtask

  task automatic check_main(input logic [7:0] v);
    logic [7:0] ea, eb;
    apply_byte(v);
    ea = b256_inv(v, NU_A, N_A);
    eb = b256_inv(v, NU_B, N_B);
    if (v == 8'h00) begin
      check(a_out == 8'h00, "R2", a_out, 0);
    end else begin
      check(a_out == ea, "R1", a_out, ea);
      check(b_out == eb, "R8", b_out, eb);
    end
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] o;
    int seed_sink;
    a_in = 8'h00; b_in = 8'h00;
    m16_x = '0; m16_y = '0; m16_xf = '0; m16_yf = '0;
    i16_c = '0; s16_a = '0; m4_e = '0; m4_f = '0; m4_ef = 1'b0; m4_ff = 1'b0;
    seed_sink = $urandom(32'h5EED_0417);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-time state: zero input gives zero output (R2)
    #1;
    check(a_out == 8'h00, "R2", a_out, 0);
    check(b_out == 8'h00, "R2", b_out, 0);

    // directed corners: unit, single-half and single-pair bytes (R1, R8)
    check_main(8'hFF);
    check(a_out == 8'hFF, "R1", a_out, 8'hFF);
    check_main(8'hF0);
    check_main(8'h0F);
    check_main(8'h01);
    check_main(8'h80);
    check_main(8'h00);

    // random sweep (R1, R8)
    for (int k = 0; k < 300; k++) check_main(8'($urandom_range(1, 255)));

    // exhaustive: inverse and involution (R1, R3, R8)
    for (int v = 1; v < 256; v++) begin
      check_main(8'(v));
      o = a_out;
      apply_byte(o);
      check(a_out == 8'(v), "R3", a_out, v);
    end

    // GF(2^4) inverter (R4)
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      i16_c = 4'(v);
      #1;
      check(i16_d == b16_inv(4'(v), N_A), "R4", i16_d, b16_inv(4'(v), N_A));
    end

    // GF(2^4) multiplier (R5)
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(negedge clk);
        m16_x = 4'(x); m16_y = 4'(y);
        m16_xf = m16_x[3:2] ^ m16_x[1:0];
        m16_yf = m16_y[3:2] ^ m16_y[1:0];
        #1;
        check(m16_p == b16_mul(4'(x), 4'(y), N_A), "R5", m16_p, b16_mul(4'(x), 4'(y), N_A));
      end
    end

    // GF(2^2) multiplier (R6)
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        @(negedge clk);
        m4_e = 2'(x); m4_f = 2'(y);
        m4_ef = m4_e[1] ^ m4_e[0];
        m4_ff = m4_f[1] ^ m4_f[0];
        #1;
        check(m4_p == b4_mul(2'(x), 2'(y)), "R6", m4_p, b4_mul(2'(x), 2'(y)));
      end
    end

    // square-scaler n*a^2 (R7)
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      s16_a = 4'(v);
      #1;
      check(s16_y == b16_mul(b16_mul(4'(v), 4'(v), N_A), NU_A, N_A), "R7",
            s16_y, b16_mul(b16_mul(4'(v), 4'(v), N_A), NU_A, N_A));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule